// File: doc/BRIEF.md
# Ratio-Assumed Dual-Clock Handshake Synchronizer

This block links a slow interface clock domain to a fast processing-core clock domain for a hashing engine's load/fetch handshake. Three control strobes (init, load, fetch), a small mode field and a 16-bit input word go from the slow side to the fast side. An acknowledge strobe and a 16-bit result word go from the fast side back to the slow side.

There are no asynchronous FIFOs and no request/acknowledge feedback loops. The design instead depends on a guaranteed clock relation: the fast clock runs at least twice as fast as the slow clock. On the slow side, each control level is registered, and the data and mode fields are latched at the first cycle of a strobe. On the fast side, a multi-flop chain resamples each level and a rising-edge detector turns it into a single-cycle pulse. The fast side returns its acknowledge by stretching it to a programmable number of fast cycles. The slow side resamples that stretched level, turns its rising edge into a one-cycle acknowledge and takes the result word with it.

One asynchronous reset clears both domains. Its release is synchronized separately into each clock domain.

Top module: `hsx_cdc_bridge`

## Requirements
- R1: While `rst_n` is low, all outputs of both domains are zero, with no clock edge needed. Release is resynchronized through two flops in each domain.
- R2: Each slow-side assertion of `s_init`, `s_load` or `s_fetch` produces exactly one single-fast-cycle pulse on `f_init`, `f_load` or `f_fetch`. An assertion is one or more consecutive high slow cycles after a low one.
- R3: `f_din` shows the `s_din` value sampled at the first slow edge of a load assertion. It changes only in the cycle where `f_load` is high. Later values of `s_din` during the same assertion are ignored.
- R4: `f_mode` shows the `s_mode` value sampled at the first slow edge of an init assertion. It changes only in the cycle where `f_init` is high. `s_mode` values presented with load or fetch are ignored.
- R5: A one-cycle `f_ack` holds an internal level high for exactly `ACK_HOLD_CYC` fast cycles. This produces exactly one single-slow-cycle pulse on `s_ack`.
- R6: `s_dout` takes the `f_dout` value present in the `f_ack` cycle and changes only in the cycle where `s_ack` is high. `f_dout` without `f_ack` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| s_clk | input | 1 | Slow interface clock |
| s_init | input | 1 | Slow-side start-of-message strobe |
| s_load | input | 1 | Slow-side input-word strobe |
| s_fetch | input | 1 | Slow-side result request strobe |
| s_mode | input | MODE_W (2) | Operating mode, taken with init |
| s_din | input | DATA_W (16) | Input word, taken with load |
| s_ack | output | 1 | One-slow-cycle acknowledge |
| s_dout | output | DATA_W (16) | Result word, held between acknowledges |
| f_clk | input | 1 | Fast core clock |
| f_init | output | 1 | One-fast-cycle init pulse |
| f_load | output | 1 | One-fast-cycle load pulse |
| f_fetch | output | 1 | One-fast-cycle fetch pulse |
| f_mode | output | MODE_W (2) | Mode delivered to the core |
| f_din | output | DATA_W (16) | Input word delivered to the core |
| f_ack | input | 1 | One-fast-cycle acknowledge from the core |
| f_dout | input | DATA_W (16) | Result word, valid with f_ack |

## Verification
The assertions assume the following about the inputs:
- The fast clock is at least twice the slow clock.
- Every slow strobe is separated from the next by at least one low slow cycle.
- Core acknowledges are single fast cycles, spaced so that one stretched level has ended and been seen low on the slow side before the next begins.

The stimulus keeps to these conditions. It uses an 8 ns fast clock against a 20 ns slow clock with a fixed phase offset, so edges never coincide. Strobes are driven on the slow falling edge with at least one idle slow cycle after each. Acknowledges are spaced several slow periods apart.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

  localparam int CTL_INIT  = 0;
  localparam int CTL_LOAD  = 1;
  localparam int CTL_FETCH = 2;
  localparam int NUM_CTL   = 3;

  typedef logic [NUM_CTL-1:0] ctl_vec_t;

  function automatic logic rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic int unsigned hold_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hsx_rst_sync.sv
module hsx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsx_edge_sync.sv
module hsx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic edge_o
);
  logic [STAGES-1:0] samp_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      last_q <= 1'b0;
    end else begin
      samp_q <= {samp_q[STAGES-2:0], lvl_i};
      last_q <= samp_q[STAGES-1];
    end
  end

  assign edge_o = hsx_pkg::rise(samp_q[STAGES-1], last_q);
endmodule

// File: rtl/hsx_ack_stretch.sv
module hsx_ack_stretch #(
  parameter int HOLD = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  output logic hold_o
);
  localparam int CW = hsx_pkg::hold_cnt_w(HOLD);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (ack_i)          left_q <= CW'(HOLD);
    else if (left_q != '0)   left_q <= left_q - CW'(1);
  end

  assign hold_o = (left_q != '0);
endmodule

// File: rtl/hsx_cdc_bridge.sv
module hsx_cdc_bridge #(
  parameter int DATA_W       = 16,
  parameter int MODE_W       = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int ACK_HOLD_CYC = 6
) (
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_init,
  input  logic              s_load,
  input  logic              s_fetch,
  input  logic [MODE_W-1:0] s_mode,
  input  logic [DATA_W-1:0] s_din,
  output logic              s_ack,
  output logic [DATA_W-1:0] s_dout,
  input  logic              f_clk,
  output logic              f_init,
  output logic              f_load,
  output logic              f_fetch,
  output logic [MODE_W-1:0] f_mode,
  output logic [DATA_W-1:0] f_din,
  input  logic              f_ack,
  input  logic [DATA_W-1:0] f_dout
);
  import hsx_pkg::*;

  // per-domain reset release
  logic s_rst_n_w, f_rst_n_w;

  hsx_rst_sync #(.STAGES(2)) u_s_rst (.clk(s_clk), .rst_n(rst_n), .rst_n_o(s_rst_n_w));
  hsx_rst_sync #(.STAGES(2)) u_f_rst (.clk(f_clk), .rst_n(rst_n), .rst_n_o(f_rst_n_w));

  // slow side: registered control levels, capture on first cycle
  ctl_vec_t          s_ctl_in, s_ctl_q, s_ctl_first;
  logic [DATA_W-1:0] s_din_hold;
  logic [MODE_W-1:0] s_mode_hold;

  assign s_ctl_in = {s_fetch, s_load, s_init};

  always_comb begin
    for (int i = 0; i < NUM_CTL; i++) s_ctl_first[i] = rise(s_ctl_in[i], s_ctl_q[i]);
  end

  always_ff @(posedge s_clk or negedge s_rst_n_w) begin
    if (!s_rst_n_w) begin
      s_ctl_q     <= '0;
      s_din_hold  <= '0;
      s_mode_hold <= '0;
    end else begin
      s_ctl_q <= s_ctl_in;
      if (s_ctl_first[CTL_LOAD]) s_din_hold  <= s_din;
      if (s_ctl_first[CTL_INIT]) s_mode_hold <= s_mode;
    end
  end

  // fast side: resample each level and detect its rising edge
  ctl_vec_t f_ctl_edge, f_pulse_q;

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl_sync
    hsx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (f_clk),
      .rst_n (f_rst_n_w),
      .lvl_i (s_ctl_q[g]),
      .edge_o(f_ctl_edge[g])
    );
  end

  logic [DATA_W-1:0] f_din_q;
  logic [MODE_W-1:0] f_mode_q;

  always_ff @(posedge f_clk or negedge f_rst_n_w) begin
    if (!f_rst_n_w) begin
      f_pulse_q <= '0;
      f_din_q   <= '0;
      f_mode_q  <= '0;
    end else begin
      f_pulse_q <= f_ctl_edge;
      if (f_ctl_edge[CTL_LOAD]) f_din_q  <= s_din_hold;
      if (f_ctl_edge[CTL_INIT]) f_mode_q <= s_mode_hold;
    end
  end

  assign f_init  = f_pulse_q[CTL_INIT];
  assign f_load  = f_pulse_q[CTL_LOAD];
  assign f_fetch = f_pulse_q[CTL_FETCH];
  assign f_din   = f_din_q;
  assign f_mode  = f_mode_q;

  // fast to slow: stretched acknowledge plus held result word
  logic              f_ack_hold;
  logic [DATA_W-1:0] f_dout_hold;

  hsx_ack_stretch #(.HOLD(ACK_HOLD_CYC)) u_stretch (
    .clk   (f_clk),
    .rst_n (f_rst_n_w),
    .ack_i (f_ack),
    .hold_o(f_ack_hold)
  );

  always_ff @(posedge f_clk or negedge f_rst_n_w) begin
    if (!f_rst_n_w)  f_dout_hold <= '0;
    else if (f_ack)  f_dout_hold <= f_dout;
  end

  logic              s_ack_edge, s_ack_q;
  logic [DATA_W-1:0] s_dout_q;

  hsx_edge_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (s_clk),
    .rst_n (s_rst_n_w),
    .lvl_i (f_ack_hold),
    .edge_o(s_ack_edge)
  );

  always_ff @(posedge s_clk or negedge s_rst_n_w) begin
    if (!s_rst_n_w) begin
      s_ack_q  <= 1'b0;
      s_dout_q <= '0;
    end else begin
      s_ack_q <= s_ack_edge;
      if (s_ack_edge) s_dout_q <= f_dout_hold;
    end
  end

  assign s_ack  = s_ack_q;
  assign s_dout = s_dout_q;
endmodule

// File: rtl/hsx_cdc_bridge_chk.sv
module hsx_cdc_bridge_chk #(
  parameter int DATA_W       = 16,
  parameter int MODE_W       = 2,
  parameter int ACK_HOLD_CYC = 6
) (
  input logic              f_clk,
  input logic              s_clk,
  input logic              f_rst_n,
  input logic              s_rst_n,
  input logic              f_init,
  input logic              f_load,
  input logic              f_fetch,
  input logic [MODE_W-1:0] f_mode,
  input logic [DATA_W-1:0] f_din,
  input logic              ack_hold,
  input logic              s_ack,
  input logic [DATA_W-1:0] s_dout
);
  logic [15:0] run_q;

  always_ff @(posedge f_clk or negedge f_rst_n) begin
    if (!f_rst_n)      run_q <= '0;
    else if (ack_hold) run_q <= run_q + 16'd1;
    else               run_q <= '0;
  end

  AST_LOAD_SINGLE: assert property (@(posedge f_clk) disable iff (!f_rst_n) f_load |=> !f_load); // R2
  AST_INIT_SINGLE: assert property (@(posedge f_clk) disable iff (!f_rst_n) f_init |=> !f_init); // R2
  AST_FETCH_SINGLE: assert property (@(posedge f_clk) disable iff (!f_rst_n) f_fetch |=> !f_fetch); // R2
  AST_FDIN_HOLD: assert property (@(posedge f_clk) disable iff (!f_rst_n) !$stable(f_din) |-> f_load); // R3
  AST_FMODE_HOLD: assert property (@(posedge f_clk) disable iff (!f_rst_n) !$stable(f_mode) |-> f_init); // R4
  AST_ACK_STRETCH_LEN: assert property (@(posedge f_clk) disable iff (!f_rst_n) $fell(ack_hold) |-> (run_q == 16'(ACK_HOLD_CYC))); // R5
  AST_SACK_SINGLE: assert property (@(posedge s_clk) disable iff (!s_rst_n) s_ack |=> !s_ack); // R5
  AST_SDOUT_HOLD: assert property (@(posedge s_clk) disable iff (!s_rst_n) !$stable(s_dout) |-> s_ack); // R6
endmodule

bind hsx_cdc_bridge hsx_cdc_bridge_chk #(
  .DATA_W(DATA_W), .MODE_W(MODE_W), .ACK_HOLD_CYC(ACK_HOLD_CYC)
) u_chk (
  .f_clk(f_clk), .s_clk(s_clk), .f_rst_n(f_rst_n_w), .s_rst_n(s_rst_n_w),
  .f_init(f_init), .f_load(f_load), .f_fetch(f_fetch), .f_mode(f_mode),
  .f_din(f_din), .ack_hold(f_ack_hold), .s_ack(s_ack), .s_dout(s_dout)
);

// File: tb/hsx_cdc_bridge_tb_top.sv
module hsx_cdc_bridge_tb_top;
  logic        rst_n = 1'b0;
  logic        s_clk = 1'b0;
  logic        f_clk = 1'b0;
  logic        s_init = 1'b0, s_load = 1'b0, s_fetch = 1'b0;
  logic [1:0]  s_mode = '0;
  logic [15:0] s_din = '0;
  logic        s_ack;
  logic [15:0] s_dout;
  logic        f_init, f_load, f_fetch;
  logic [1:0]  f_mode;
  logic [15:0] f_din;
  logic        f_ack = 1'b0;
  logic [15:0] f_dout = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  int load_cnt = 0, init_cnt = 0, fetch_cnt = 0, ack_cnt = 0, wide_f = 0, wide_s = 0;
  logic [15:0] load_vals [0:15];
  logic pl = 0, pi = 0, pf = 0, pa = 0;

  hsx_cdc_bridge dut_i (
    .rst_n(rst_n), .s_clk(s_clk), .s_init(s_init), .s_load(s_load), .s_fetch(s_fetch),
    .s_mode(s_mode), .s_din(s_din), .s_ack(s_ack), .s_dout(s_dout),
    .f_clk(f_clk), .f_init(f_init), .f_load(f_load), .f_fetch(f_fetch),
    .f_mode(f_mode), .f_din(f_din), .f_ack(f_ack), .f_dout(f_dout)
  );

  always #4 f_clk = ~f_clk;
  initial begin #3; forever #10 s_clk = ~s_clk; end

  // monitors, sampled on falling edges
  always @(negedge f_clk) begin
    if (rst_n) begin
      if (f_load) begin load_vals[load_cnt % 16] = f_din; load_cnt++; end
      if (f_init) init_cnt++;
      if (f_fetch) fetch_cnt++;
      if ((f_load && pl) || (f_init && pi) || (f_fetch && pf)) wide_f++;
    end
    pl = f_load; pi = f_init; pf = f_fetch;
  end

  always @(negedge s_clk) begin
    if (rst_n) begin
      if (s_ack) ack_cnt++;
      if (s_ack && pa) wide_s++;
    end
    pa = s_ack;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_slow(input int which, input int ncyc, input logic [15:0] d0, input logic [15:0] d1,
                            input logic [1:0] m0, input logic [1:0] m1, input int idle);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge s_clk);
      s_din  = (c == 0) ? d0 : d1;
      s_mode = (c == 0) ? m0 : m1;
      case (which)
        0: s_init = 1'b1;
        1: s_load = 1'b1;
        default: s_fetch = 1'b1;
      endcase
    end
    @(negedge s_clk);
    s_init = 1'b0; s_load = 1'b0; s_fetch = 1'b0;
    s_din = 16'h0BAD; s_mode = 2'd3;
    repeat (idle) @(negedge s_clk);
  endtask

  task automatic drive_ack(input logic [15:0] d);
    @(negedge f_clk); f_ack = 1'b1; f_dout = d;
    @(negedge f_clk); f_ack = 1'b0; f_dout = 16'hFFFF;
    repeat (6) @(negedge s_clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge f_clk);
    chk("R1", {f_init, f_load, f_fetch, s_ack}, 0, "pulses in reset");
    chk("R1", {f_din, s_dout}, 0, "data in reset");
    chk("R1", f_mode, 0, "mode in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge s_clk);
    chk("R1", {f_init, f_load, f_fetch, s_ack}, 0, "pulses after release");
  endtask

  task automatic t_single_load;
    int b = load_cnt;
    drive_slow(1, 1, 16'hA5A5, 16'hA5A5, 2'd0, 2'd0, 5);
    chk("R2", load_cnt, b + 1, "single load pulse count");
    chk("R3", f_din, 16'hA5A5, "f_din after single load");
  endtask

  task automatic t_long_load;
    int b = load_cnt;
    drive_slow(1, 3, 16'h1111, 16'h2222, 2'd0, 2'd0, 5);
    chk("R2", load_cnt, b + 1, "held load gives one pulse");
    chk("R3", f_din, 16'h1111, "first-cycle word kept");
  endtask

  task automatic t_burst;
    int b = load_cnt;
    drive_slow(1, 1, 16'h3C3C, 16'h3C3C, 2'd0, 2'd0, 1);
    drive_slow(1, 1, 16'h4D4D, 16'h4D4D, 2'd0, 2'd0, 1);
    drive_slow(1, 1, 16'h5E5E, 16'h5E5E, 2'd0, 2'd0, 5);
    chk("R2", load_cnt, b + 3, "burst pulse count");
    chk("R3", load_vals[b % 16], 16'h3C3C, "burst word 0");
    chk("R3", load_vals[(b + 1) % 16], 16'h4D4D, "burst word 1");
    chk("R3", load_vals[(b + 2) % 16], 16'h5E5E, "burst word 2");
  endtask

  task automatic t_init_mode;
    int b = init_cnt;
    drive_slow(0, 2, 16'h0, 16'h0, 2'd2, 2'd1, 5);
    chk("R2", init_cnt, b + 1, "init pulse count");
    chk("R4", f_mode, 2'd2, "mode from first init cycle");
    drive_slow(1, 1, 16'h7777, 16'h7777, 2'd1, 2'd1, 5);
    chk("R4", f_mode, 2'd2, "mode ignored with load");
  endtask

  task automatic t_fetch;
    int bf = fetch_cnt;
    int bl = load_cnt;
    drive_slow(2, 1, 16'h0, 16'h0, 2'd0, 2'd0, 5);
    chk("R2", fetch_cnt, bf + 1, "fetch pulse count");
    chk("R2", load_cnt, bl, "fetch gives no load pulse");
    chk("R3", f_din, 16'h7777, "f_din untouched by fetch");
  endtask

  task automatic t_ack;
    int b = ack_cnt;
    drive_ack(16'h1234);
    chk("R5", ack_cnt, b + 1, "one s_ack per f_ack");
    chk("R6", s_dout, 16'h1234, "s_dout after ack");
    @(negedge f_clk); f_dout = 16'h9999;
    repeat (6) @(negedge s_clk);
    chk("R6", s_dout, 16'h1234, "f_dout without ack ignored");
    chk("R5", ack_cnt, b + 1, "no s_ack without f_ack");
    drive_ack(16'hBEEF);
    chk("R5", ack_cnt, b + 2, "second ack count");
    chk("R6", s_dout, 16'hBEEF, "s_dout after second ack");
  endtask

  task automatic t_reset_mid;
    @(negedge f_clk); rst_n = 1'b0;
    #1;
    chk("R1", {f_din, s_dout}, 0, "async clear of data");
    chk("R1", f_mode, 0, "async clear of mode");
    repeat (3) @(negedge s_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge s_clk);
    chk("R1", {f_init, f_load, f_fetch, s_ack}, 0, "quiet after re-release");
  endtask

  initial begin
    t_reset();
    t_single_load();
    t_long_load();
    t_burst();
    t_init_mode();
    t_fetch();
    t_ack();
    chk("R2", wide_f, 0, "all fast pulses one cycle wide");
    chk("R5", wide_s, 0, "all s_ack pulses one cycle wide");
    t_reset_mid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge f_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule